// File: doc/BRIEF.md
# ROM-Driven Recurrence Iterator

This block produces the sequence X(n) = X(n-1) + f(X(n-1)), starting from a seed X0 that is loaded by a strobe. The function f comes from a lookup table with a registered output. The table output is the word at the address seen at the previous rising edge, and it clears to zero under reset. The block steers the table address from the adder's next-state sum rather than from the state register. This means f of each new term is already on the table output when that term lands in the state register. No alignment register is needed, and a new term arrives on every clock.

A second cadence can be chosen at load time for comparison. In it, the table is addressed from the held state and the addition waits one extra cycle, so a term is produced every other cycle. Table contents come from a synthesizable function chosen by a parameter. Arithmetic is modulo 2^B.

Top module: `recur_iter`

## Requirements
- R1: While `rst` is 1 at a rising edge, `result` is 0 and `resValid` is 0 after that edge.
- R2: With TBL_SEL = 0 the table holds f(i) = (i*i + 3*i + 1) mod 2^B at address i, and its output changes only at rising edges.
- R3: In fast cadence (`slowMode` = 0 at the load edge), `result` equals X1 one edge after the load edge, X2 one edge later and so on. `resValid` is 1 from X1 onward and stays 1 until the next load or reset.
- R4: Each term is the previous term plus f(previous term), truncated to B bits, with no overflow indication.
- R5: In slow cadence (`slowMode` = 1 at the load edge), term Xk appears 2k edges after the load edge. `resValid` is 1 only in the cycle following those edges and 0 in the cycle between, and `result` holds its value during that cycle.
- R6: A `loadStb` sampled at an edge puts `seed` on `result` with `resValid` 0 after that edge. This restarts the sequence even in the middle of a run.
- R7: `slowMode` is sampled only at a load edge. Changing it during a run leaves the cadence and values of that run unchanged.
- R8: After reset and before the first load, `resValid` stays 0 and `result` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadStb | input | 1 | Load strobe for a new seed |
| seed | input | B | Seed value X0 |
| slowMode | input | 1 | Cadence select, sampled at load: 0 one term per cycle, 1 one term per two cycles |
| result | output | B | Current term |
| resValid | output | 1 | High when `result` is a new term of the running sequence |

## Verification
The load edge shows up one edge later as `result` = seed with `resValid` low. In fast cadence term Xk is due exactly k edges after the load edge. In slow cadence it is due 2k edges after the load edge, with a held, invalid cycle at each odd edge. The bench drives inputs on falling edges and samples on the falling edge that follows each counted rising edge, so every comparison lands on the one cycle where its term is due. A reference model with a combinational table computes each expected term by index. Runs start from seeds 0, 255 and others chosen so that the sum wraps.

// File: rtl/recur_pkg.sv
package recur_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FAST,
    ST_SLOW_READ,
    ST_SLOW_ADD
  } iterState_t;

  typedef enum logic [1:0] {
    ADDR_SEED,
    ADDR_SUM,
    ADDR_HELD
  } addrSel_t;

  typedef struct packed {
    logic     takeSeed;
    logic     takeSum;
    addrSel_t addrSel;
  } ctrlStrobes_t;

  // Quadratic table content: i*i + 3*i + 1, caller truncates to word width.
  function automatic logic [31:0] quadWord(input logic [31:0] idx);
    return idx * idx + idx * 32'd3 + 32'd1;
  endfunction

endpackage

// File: rtl/recur_table.sv
module recur_table #(
  parameter int B       = 8,
  parameter int TBL_SEL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [B-1:0] addr,
  output logic [B-1:0] word
);
  import recur_pkg::*;

  logic [B-1:0] nextWord;

  generate
    if (TBL_SEL == 0) begin : g_quad
      logic [31:0] wide;
      assign wide     = quadWord(32'(addr));
      assign nextWord = wide[B-1:0];
    end else begin : g_inv
      assign nextWord = ~addr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else     word <= nextWord;
  end

endmodule

// File: rtl/recur_datapath.sv
module recur_datapath #(
  parameter int B       = 8,
  parameter int TBL_SEL = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [B-1:0]            seed,
  input  recur_pkg::ctrlStrobes_t strobes,
  output logic [B-1:0]            xTerm,
  output logic [B-1:0]            romWord
);
  import recur_pkg::*;

  logic [B-1:0] xReg;
  logic [B-1:0] sumTerm;
  logic [B-1:0] tblAddr;

  assign sumTerm = xReg + romWord;

  always_comb begin
    unique case (strobes.addrSel)
      ADDR_SEED: tblAddr = seed;
      ADDR_SUM:  tblAddr = sumTerm;
      default:   tblAddr = xReg;
    endcase
  end

  recur_table #(.B(B), .TBL_SEL(TBL_SEL)) u_table (
    .clk  (clk),
    .rst  (rst),
    .addr (tblAddr),
    .word (romWord)
  );

  always_ff @(posedge clk) begin
    if (rst)                  xReg <= '0;
    else if (strobes.takeSeed) xReg <= seed;
    else if (strobes.takeSum)  xReg <= sumTerm;
  end

  assign xTerm = xReg;

endmodule

// File: rtl/recur_ctrl.sv
module recur_ctrl (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    loadStb,
  input  logic                    slowMode,
  output recur_pkg::ctrlStrobes_t strobes,
  output logic                    resValid
);
  import recur_pkg::*;

  iterState_t state, stateNext;
  logic       stepNow;

  assign stepNow = !loadStb && (state == ST_FAST || state == ST_SLOW_ADD);

  always_comb begin
    stateNext = state;
    if (loadStb) begin
      stateNext = slowMode ? ST_SLOW_READ : ST_FAST;
    end else begin
      unique case (state)
        ST_SLOW_READ: stateNext = ST_SLOW_ADD;
        ST_SLOW_ADD:  stateNext = ST_SLOW_READ;
        default:      stateNext = state;
      endcase
    end
  end

  always_comb begin
    strobes.takeSeed = loadStb;
    strobes.takeSum  = stepNow;
    if (loadStb)                strobes.addrSel = ADDR_SEED;
    else if (state == ST_FAST)  strobes.addrSel = ADDR_SUM;
    else                        strobes.addrSel = ADDR_HELD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      resValid <= 1'b0;
    end else begin
      state    <= stateNext;
      resValid <= stepNow;
    end
  end

endmodule

// File: rtl/recur_iter.sv
module recur_iter #(
  parameter int B       = 8,
  parameter int TBL_SEL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loadStb,
  input  logic [B-1:0] seed,
  input  logic         slowMode,
  output logic [B-1:0] result,
  output logic         resValid
);
  import recur_pkg::*;

  ctrlStrobes_t strobes;
  logic [B-1:0] romWord;

  recur_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .loadStb  (loadStb),
    .slowMode (slowMode),
    .strobes  (strobes),
    .resValid (resValid)
  );

  recur_datapath #(.B(B), .TBL_SEL(TBL_SEL)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .seed    (seed),
    .strobes (strobes),
    .xTerm   (result),
    .romWord (romWord)
  );

endmodule

// File: rtl/recur_iter_chk.sv
module recur_iter_chk #(
  parameter int B = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         loadStb,
  input logic         slowMode,
  input logic [B-1:0] seed,
  input logic [B-1:0] result,
  input logic         resValid,
  input logic [B-1:0] romWord
);

  logic slowRun;
  logic everLoaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      slowRun    <= 1'b0;
      everLoaded <= 1'b0;
    end else if (loadStb) begin
      slowRun    <= slowMode;
      everLoaded <= 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0 && !resValid)); // R1

  AST_LOAD_TAKES_SEED: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> (result == $past(seed) && !resValid)); // R6

  AST_FAST_STEP_SUM: assert property (@(posedge clk) disable iff (rst)
    (resValid && !slowRun && !loadStb) |=> (result == B'($past(result) + $past(romWord)))); // R4

  AST_FAST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (resValid && !slowRun && !loadStb) |=> resValid); // R3

  AST_SLOW_PULSE: assert property (@(posedge clk) disable iff (rst)
    (resValid && slowRun && !loadStb) |=> (!resValid && $stable(result))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !everLoaded |-> (!resValid && result == '0)); // R8

endmodule

bind recur_iter recur_iter_chk #(.B(B)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .loadStb  (loadStb),
  .slowMode (slowMode),
  .seed     (seed),
  .result   (result),
  .resValid (resValid),
  .romWord  (romWord)
);

// File: tb/recur_iter_tb.sv
`timescale 1ns/1ps
module recur_iter_tb;

  localparam int B = 8;
  localparam int NVEC = 6;
  localparam int NTERMS = 10;
  // {slowMode, seed}
  localparam logic [B:0] VECS [NVEC] = '{
    {1'b0, 8'd0}, {1'b0, 8'd255}, {1'b0, 8'd200},
    {1'b1, 8'd17}, {1'b0, 8'd128}, {1'b1, 8'd254}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         loadStb = 1'b0;
  logic [B-1:0] seed = '0;
  logic         slowMode = 1'b0;
  logic [B-1:0] result;
  logic         resValid;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  recur_iter #(.B(B), .TBL_SEL(0)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .loadStb  (loadStb),
    .seed     (seed),
    .slowMode (slowMode),
    .result   (result),
    .resValid (resValid)
  );

  // R2: reference table, combinational read
  function automatic logic [B-1:0] fRef(input logic [B-1:0] x);
    logic [31:0] w;
    w = 32'(x) * 32'(x) + 32'(x) * 32'd3 + 32'd1;
    return w[B-1:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Load at the next edge, then follow nTerms terms with the reference model.
  task automatic runSeq(input logic mode, input logic [B-1:0] s, input int nTerms,
                        input logic flipMode);
    logic [B-1:0] x;
    logic [B-1:0] prev;
    seed     = s;
    slowMode = mode;
    loadStb  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    loadStb = 1'b0;
    if (flipMode) slowMode = ~mode;
    chk("R6 result after load", int'(result), int'(s));
    chk("R6 valid after load", int'(resValid), 0);
    x = s;
    for (int k = 1; k <= nTerms; k++) begin
      prev = x;
      x = x + fRef(x);  // R4 wraps modulo 2^B
      if (mode) begin
        @(negedge clk);
        chk("R5 valid between terms", int'(resValid), 0);
        chk("R5 result held", int'(result), int'(prev));
        @(negedge clk);
        chk("R5 slow term", int'(result), int'(x));
        chk("R5 slow valid", int'(resValid), 1);
      end else begin
        @(negedge clk);
        chk(flipMode ? "R7 fast term" : "R3 R4 fast term", int'(result), int'(x));
        chk("R3 fast valid", int'(resValid), 1);
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 result in reset", int'(result), 0);
    chk("R1 valid in reset", int'(resValid), 0);
    rst = 1'b0;
    // R8 idle before any load, mode toggling has no effect
    for (int i = 0; i < 4; i++) begin
      slowMode = ~slowMode;
      @(negedge clk);
      chk("R8 idle result", int'(result), 0);
      chk("R8 idle valid", int'(resValid), 0);
    end

    // Vector table: back-to-back loads also restart mid-run (R6)
    for (int v = 0; v < NVEC; v++) begin
      runSeq(VECS[v][B], VECS[v][B-1:0], NTERMS, 1'b0);
    end

    // R7: mode changes during a run are ignored
    runSeq(1'b0, 8'd9, 6, 1'b1);
    runSeq(1'b1, 8'd77, 4, 1'b1);

    // R6: load in the middle of a slow run, right at a held cycle
    runSeq(1'b1, 8'd3, 1, 1'b0);
    @(negedge clk);
    runSeq(1'b0, 8'd250, 5, 1'b0);

    // R1 reset mid-run, then R8 idle again
    rst = 1'b1;
    @(negedge clk);
    chk("R1 result after mid-run reset", int'(result), 0);
    chk("R1 valid after mid-run reset", int'(resValid), 0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 idle after reset result", int'(result), 0);
      chk("R8 idle after reset valid", int'(resValid), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule